// File: doc/BRIEF.md
# Partial Reconfiguration Status Monitor

This block watches the status byte that an on-chip configuration port returns while partial bitstreams are streamed through it. It registers the byte once, decodes only its upper nibble, and follows each load through idle, synchronised, error, retry and busy phases. A load that returns from the synchronised state to idle without an error is reported with a one-cycle success pulse.

A short CRC error notice arrives as a two-cycle status pattern: a transition code for one cycle, then a steady error code. The block counts that pattern as one CRC error and sets a sticky flag. When software reloads the bitstream, the same transition code comes back as part of the retry, and the block must not count it again. A separate active-low error-pulse input clears itself after each bitstream segment, so the block holds it in its own sticky flag.

The block also counts rising edges on a done input, which can pulse several times during one partial load, without treating any one of them as the end of the load. A recovery controller or a debug capture unit reads the phase, the flags and the counters.

Top module: `cfg_status_monitor`

## Requirements
- R1: Only bits 7:4 of `stat_word` affect the block. Bits 31:8 and bits 3:0 have no effect on any output.
- R2: Status nibble encoding: bit 7 = 1 means no configuration error, bit 6 = 1 means sync received, bit 5 = 1 means readback active, bit 4 = 0 means abort active. `stat_word` is registered once, so `phase` reflects a new value after the second rising clock edge. Phase codes: 0 idle, 1 synced, 2 error-edge, 3 error, 4 retry, 5 busy.
- R3: Nibble 0xD followed by 0x9 (a desync with no error, from phase synced) gives exactly one cycle of `load_ok`, increments `load_ok_cnt` and sets phase idle. The pulse appears in the same cycle as the phase change.
- R4: Nibble 0x5 or 0x1 arriving from phase idle or synced counts one CRC error: `crc_err_cnt` increments and `crc_err_flag` sets. A 0x5 gives phase 2, then 0x1 gives phase 3, with no second count. `clr` releases `crc_err_flag`.
- R5: Nibble 0x5 arriving from phase error gives phase 4 (retry) and does not count an error. A following 0xD gives phase 1.
- R6: Any nibble with the readback bit at 1 or the abort bit at 0 gives phase 5. In phase 5 no error is counted and no success is reported. When both bits return to idle, the phase is chosen from the nibble alone (0x9 idle, 0xD synced, 0x5 retry, 0x1 error).
- R7: `err_pulse_n` at 0 for a single cycle sets `err_pin_flag` from the next edge onward. Only `clr` releases the flag, and if a set and `clr` fall in the same cycle, the set wins.
- R8: Each rising edge of `done_pulse` increments `done_cnt`. `clr` returns `done_cnt` to 0. `done_pulse` has no effect on the phase or on `load_ok`.
- R9: All counters saturate at 255 and do not wrap.
- R10: After reset, `phase` is 0 and all flags, pulses and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stat_word | input | 32 | Status bus from the configuration port |
| err_pulse_n | input | 1 | Active-low error pulse, clears itself after each segment |
| done_pulse | input | 1 | Completion strobe, may pulse several times per load |
| clr | input | 1 | Releases the sticky flags and clears `done_cnt` |
| phase | output | 3 | Current phase code |
| load_ok | output | 1 | One-cycle pulse on a successful load |
| crc_err_flag | output | 1 | Sticky flag for a CRC error seen in the status sequence |
| err_pin_flag | output | 1 | Sticky copy of `err_pulse_n` going low |
| crc_err_cnt | output | 8 | Saturating count of CRC errors |
| load_ok_cnt | output | 8 | Saturating count of successful loads |
| done_cnt | output | 8 | Saturating count of done events |

## Verification
The bench runs every ordered pair of the 16 status nibbles against a phase model written from the requirements. While it does so, it fills the reserved bits and the upper 24 bits with random values. This sweep reaches the cases a careless design gets wrong:
- a retry's transition code counted as a second CRC error;
- the transition code taken as a steady error;
- a success reported on leaving the error or busy phase;
- a decoder that looks at the reserved low nibble, which would change the phase when the device family changes.

The bench then drives long error and success sequences past 255, where a counter that wraps would read back a small number. It also drives single-cycle error and done pulses. A design that samples levels instead of holding a flag or detecting edges would lose those pulses or count them more than once.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_SYNCED   = 3'd1,
    PH_ERR_EDGE = 3'd2,
    PH_ERROR    = 3'd3,
    PH_RETRY    = 3'd4,
    PH_BUSY     = 3'd5
  } phase_t;

  // decoded status nibble, MSB first
  typedef struct packed {
    logic cfg_ok;   // 1 = no configuration error
    logic synced;   // 1 = sync word received
    logic rdbk;     // 1 = readback active
    logic abort_n;  // 0 = abort active
  } stat_t;
endpackage

// File: rtl/cfgmon_decode.sv
module cfgmon_decode #(
  parameter int STAT_W  = 32,
  parameter int NIB_LSB = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STAT_W-1:0]     stat_in,
  output cfgmon_pkg::stat_t     st_q,
  output logic                  busy
);
  localparam int NIB_MSB = NIB_LSB + 3;

  cfgmon_pkg::stat_t st_d;
  logic unused_bits;

  assign st_d        = cfgmon_pkg::stat_t'(stat_in[NIB_MSB:NIB_LSB]);
  assign unused_bits = ^{stat_in[STAT_W-1:NIB_MSB+1], stat_in[NIB_LSB-1:0]};

  // idle reset value: no error, not synced, no readback, no abort
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 4'b1001;
    else        st_q <= st_d;
  end

  assign busy = st_q.rdbk | ~st_q.abort_n;
endmodule

// File: rtl/cfgmon_fsm.sv
module cfgmon_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  cfgmon_pkg::stat_t   st,
  input  logic                busy,
  output cfgmon_pkg::phase_t  phase,
  output logic                crc_evt,
  output logic                ok_evt,
  output logic                ok_pulse
);
  import cfgmon_pkg::*;

  phase_t ph_q, ph_nxt;

  always_comb begin
    ph_nxt  = ph_q;
    crc_evt = 1'b0;
    ok_evt  = 1'b0;
    if (busy) begin
      ph_nxt = PH_BUSY;
    end else begin
      case ({st.cfg_ok, st.synced})
        2'b10: begin
          ph_nxt = PH_IDLE;
          ok_evt = (ph_q == PH_SYNCED);
        end
        2'b11: ph_nxt = PH_SYNCED;
        2'b01: begin
          if (ph_q == PH_IDLE || ph_q == PH_SYNCED) begin
            ph_nxt  = PH_ERR_EDGE;
            crc_evt = 1'b1;
          end else if (ph_q == PH_ERR_EDGE) begin
            ph_nxt = PH_ERR_EDGE;
          end else begin
            ph_nxt = PH_RETRY;
          end
        end
        default: begin
          ph_nxt  = PH_ERROR;
          crc_evt = (ph_q == PH_IDLE || ph_q == PH_SYNCED);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      ok_pulse <= 1'b0;
    end else begin
      ph_q     <= ph_nxt;
      ok_pulse <= ok_evt;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/cfgmon_satcnt.sv
module cfgmon_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  assign cnt_en  = clr | (inc & (cnt != MAX));
  assign cnt_nxt = clr ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/cfgmon_sticky.sv
module cfgmon_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= 1'b0;
    else if (set | clr) q <= set;
  end
endmodule

// File: rtl/cfg_status_monitor.sv
module cfg_status_monitor #(
  parameter int STAT_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STAT_W-1:0] stat_word,
  input  logic             err_pulse_n,
  input  logic             done_pulse,
  input  logic             clr,
  output logic [2:0]       phase,
  output logic             load_ok,
  output logic             crc_err_flag,
  output logic             err_pin_flag,
  output logic [CNT_W-1:0] crc_err_cnt,
  output logic [CNT_W-1:0] load_ok_cnt,
  output logic [CNT_W-1:0] done_cnt
);
  localparam int NCNT = 3;

  logic [1:0]        rst_sh;
  logic              rst_q;
  cfgmon_pkg::stat_t st_q;
  cfgmon_pkg::phase_t ph;
  logic              busy, crc_evt, ok_evt, done_q;
  logic [NCNT-1:0]   cnt_inc, cnt_clr;
  logic [CNT_W-1:0]  cnt_val [NCNT];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q = rst_sh[1];

  cfgmon_decode #(.STAT_W(STAT_W), .NIB_LSB(4)) i_dec (
    .clk(clk), .rst_n(rst_q), .stat_in(stat_word), .st_q(st_q), .busy(busy)
  );

  cfgmon_fsm i_fsm (
    .clk(clk), .rst_n(rst_q), .st(st_q), .busy(busy), .phase(ph),
    .crc_evt(crc_evt), .ok_evt(ok_evt), .ok_pulse(load_ok)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) done_q <= 1'b0;
    else        done_q <= done_pulse;
  end

  assign cnt_inc = {done_pulse & ~done_q, ok_evt, crc_evt};
  assign cnt_clr = {clr, 1'b0, 1'b0};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    cfgmon_satcnt #(.W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_q), .clr(cnt_clr[g]), .inc(cnt_inc[g]), .cnt(cnt_val[g])
    );
  end

  cfgmon_sticky i_crc_flag (
    .clk(clk), .rst_n(rst_q), .set(crc_evt), .clr(clr), .q(crc_err_flag)
  );
  cfgmon_sticky i_pin_flag (
    .clk(clk), .rst_n(rst_q), .set(~err_pulse_n), .clr(clr), .q(err_pin_flag)
  );

  assign phase       = ph;
  assign crc_err_cnt = cnt_val[0];
  assign load_ok_cnt = cnt_val[1];
  assign done_cnt    = cnt_val[2];
endmodule

// File: rtl/cfgmon_chk.sv
module cfgmon_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       phase,
  input logic             load_ok,
  input logic             crc_err_flag,
  input logic             err_pin_flag,
  input logic             err_pulse_n,
  input logic             clr,
  input logic [CNT_W-1:0] crc_err_cnt,
  input logic [CNT_W-1:0] load_ok_cnt
);
  import cfgmon_pkg::*;
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  // R3
  ok_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !load_ok);
  // R3
  ok_from_synced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SYNCED) ##1 load_ok |-> phase == PH_IDLE);
  // R5
  retry_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RETRY) |=> $stable(crc_err_cnt));
  // R6
  busy_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BUSY) |=> ($stable(crc_err_cnt) && !load_ok));
  // R7
  pin_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse_n |=> err_pin_flag);
  // R4
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_flag && !clr) |=> crc_err_flag);
  // R9
  crc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_cnt == MAX) |=> (crc_err_cnt == MAX));
  // R9
  ok_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok_cnt == MAX) |=> (load_ok_cnt == MAX));
endmodule

bind cfg_status_monitor cfgmon_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_q), .phase(phase), .load_ok(load_ok),
  .crc_err_flag(crc_err_flag), .err_pin_flag(err_pin_flag),
  .err_pulse_n(err_pulse_n), .clr(clr),
  .crc_err_cnt(crc_err_cnt), .load_ok_cnt(load_ok_cnt)
);

// File: tb/test_cfg_status_monitor.sv
`timescale 1ns/1ps
module test_cfg_status_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] stat_word;
  logic        err_pulse_n, done_pulse, clr;
  logic [2:0]  phase;
  logic        load_ok, crc_err_flag, err_pin_flag;
  logic [7:0]  crc_err_cnt, load_ok_cnt, done_cnt;

  int total = 0;
  int bad   = 0;
  int exp_ph, exp_crc, exp_ok;
  bit exp_okp, exp_cst;

  always #2 clk = ~clk;

  cfg_status_monitor i_cfg_status_monitor (
    .clk(clk), .rst_n(rst_n), .stat_word(stat_word), .err_pulse_n(err_pulse_n),
    .done_pulse(done_pulse), .clr(clr), .phase(phase), .load_ok(load_ok),
    .crc_err_flag(crc_err_flag), .err_pin_flag(err_pin_flag),
    .crc_err_cnt(crc_err_cnt), .load_ok_cnt(load_ok_cnt), .done_cnt(done_cnt)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // expected phase model from the requirements
  task automatic model(input logic [3:0] n);
    exp_okp = 1'b0;
    if (n[1] || !n[0]) exp_ph = 5;
    else case ({n[3], n[2]})
      2'b10: begin
        if (exp_ph == 1) begin exp_okp = 1'b1; if (exp_ok < 255) exp_ok++; end
        exp_ph = 0;
      end
      2'b11: exp_ph = 1;
      2'b01: begin
        if (exp_ph <= 1) begin exp_ph = 2; exp_cst = 1'b1; if (exp_crc < 255) exp_crc++; end
        else if (exp_ph != 2) exp_ph = 4;
      end
      default: begin
        if (exp_ph <= 1) begin exp_cst = 1'b1; if (exp_crc < 255) exp_crc++; end
        exp_ph = 3;
      end
    endcase
  endtask

  // R1 R2: random filler outside bits 7:4, result after two edges
  task automatic apply(input logic [3:0] n, input bit full);
    stat_word = {$urandom(), n, 4'($urandom())} ;
    model(n);
    @(negedge clk);
    @(negedge clk);
    chk("R2 phase", phase, exp_ph);
    if (full) begin
      chk("R3 load_ok", load_ok, exp_okp);
      chk("R4 crc_err_cnt", crc_err_cnt, exp_crc);
      chk("R3 load_ok_cnt", load_ok_cnt, exp_ok);
      chk("R4 crc_err_flag", crc_err_flag, exp_cst);
    end
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stat_word = 32'h9F; err_pulse_n = 1'b1; done_pulse = 1'b0; clr = 1'b0;
    exp_ph = 0; exp_crc = 0; exp_ok = 0; exp_okp = 0; exp_cst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10
    chk("R10 phase", phase, 0);
    chk("R10 load_ok", load_ok, 0);
    chk("R10 crc_err_flag", crc_err_flag, 0);
    chk("R10 err_pin_flag", err_pin_flag, 0);
    chk("R10 counts", crc_err_cnt + load_ok_cnt + done_cnt, 0);

    // directed sequences: R3 success, R4 error edge, R5 retry
    apply(4'hD, 1'b1); apply(4'h9, 1'b1);
    chk("R3 ok pulse", load_ok, 1);
    @(negedge clk); chk("R3 one cycle", load_ok, 0);
    apply(4'hD, 1'b1); apply(4'h5, 1'b1);
    chk("R4 edge phase", phase, 2);
    apply(4'h1, 1'b1); chk("R4 error phase", phase, 3); chk("R4 single count", crc_err_cnt, 1);
    apply(4'h5, 1'b1); chk("R5 retry phase", phase, 4); chk("R5 no count", crc_err_cnt, 1);
    apply(4'hD, 1'b1); chk("R5 resynced", phase, 1);
    apply(4'h7, 1'b1); chk("R6 busy", phase, 5);
    apply(4'h9, 1'b1); chk("R6 no success after busy", load_ok_cnt, 1);

    // near-exhaustive: every ordered pair of nibbles
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(4'(a), 1'b1);
        apply(4'(b), 1'b1);
      end

    // R4 clear of the sticky flag
    apply(4'h9, 1'b1);
    clr = 1'b1; @(negedge clk); clr = 1'b0; exp_cst = 1'b0;
    chk("R4 flag cleared", crc_err_flag, 0);

    // R9 saturation
    apply(4'hD, 1'b0);
    for (int i = 0; i < 260; i++) begin apply(4'h1, 1'b0); apply(4'hD, 1'b0); end
    chk("R9 crc sat", crc_err_cnt, 255);
    for (int i = 0; i < 260; i++) begin apply(4'h9, 1'b0); apply(4'hD, 1'b0); end
    chk("R9 ok sat", load_ok_cnt, 255);

    // R7 sticky pin flag
    err_pulse_n = 1'b0; @(negedge clk); err_pulse_n = 1'b1;
    chk("R7 set", err_pin_flag, 1);
    repeat (5) @(negedge clk);
    chk("R7 held", err_pin_flag, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R7 cleared", err_pin_flag, 0);
    err_pulse_n = 1'b0; clr = 1'b1; @(negedge clk); err_pulse_n = 1'b1; clr = 1'b0;
    chk("R7 set wins", err_pin_flag, 1);

    // R8 done edges
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R8 cleared", done_cnt, 0);
    for (int i = 0; i < 3; i++) begin
      done_pulse = 1'b1; @(negedge clk); @(negedge clk);
      done_pulse = 1'b0; @(negedge clk);
    end
    chk("R8 three edges", done_cnt, 3);
    chk("R8 phase unchanged", phase, 1);
    chk("R8 no success", load_ok, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule